// File: doc/BRIEF.md
# Two-Register 16-bit Processor Core

This block is a single-cycle processor core with an address register A, a data register D and a 15-bit program counter. In every cycle it decodes the word presented on its instruction input, which an external instruction ROM supplies from the address on `pc`. It reads data memory through `in_m` and writes it through `out_m`, `addr_m` and `wr_m`. An external data RAM is attached to these pins.

The most significant bit picks the kind of instruction. An address-type word (top bit 0) loads itself into A unchanged, so A holds a 15-bit unsigned constant. A compute-type word (top bit 1) steers a small ALU whose X operand is always D and whose Y operand is A or `in_m`. The result can go to A, D and memory in any combination. The word can also send the program counter to the address held in A, based on the sign of the result.

The data memory address is the low bits of A at all times. The ALU result is on `out_m` at all times. Only `wr_m` decides whether anything is stored.

Top module: `acc16_core`

## Requirements
- R1: An instruction with bit 15 = 0 loads the full 16-bit word into A at the next rising edge, does not write memory, and advances the pc by one.
- R2: `addr_m` always equals A[14:0]. This holds with no check of instruction type, and also when A was loaded with a value whose bit 15 is set.
- R3: `out_m` always carries the current ALU result, including during address-type cycles. In those cycles the ALU uses bits 12:6 of the word as its controls.
- R4: ALU controls: bit 12 selects Y (0 = A, 1 = `in_m`) and X is D. Bit 11 zeroes X, bit 10 inverts X, bit 9 zeroes Y and bit 8 inverts Y, applied in that order. Bit 7 picks X+Y (1) or X&Y (0). Bit 6 inverts the result.
- R5: In a compute-type word, bit 5 loads A, bit 4 loads D and bit 3 stores to memory, each independently. `wr_m` is high only when bit 15 and bit 3 are both 1.
- R6: In a compute-type word, bit 2 jumps on a negative result, bit 1 on a zero result and bit 0 on a positive result, in any combination. A taken jump loads A[14:0] into the pc. Otherwise the pc increments and wraps from 0x7FFF to 0.
- R7: A synchronous reset sets the pc, A and D to 0 at the rising edge.
- R8: A, D and the pc change only at the rising edge. A jump taken in the same word that loads A uses the old value of A, and `addr_m` shows the new A from the next cycle.
- R9: In an address-type word, bits 5:0 have no effect: D keeps its value, `wr_m` stays low and no jump is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word from the instruction ROM |
| in_m | input | 16 | Data read from data memory at `addr_m` |
| out_m | output | 16 | ALU result, the data to store |
| addr_m | output | 15 | Data memory address, A[14:0] |
| wr_m | output | 1 | Data memory write enable |
| pc | output | 15 | Address of the next instruction to fetch |

## Verification
A wrong value in A shows on `addr_m` in the cycle after the edge that loaded it. A wrong value in D stays hidden until a later compute word reads D, and then shows on `out_m` in that same cycle. A wrong jump decision or a wrong increment shows on `pc` one edge later. After that, every following pc value is off as well. The bench therefore keeps a reference copy of A, D and the pc, and compares all four outputs in every cycle. It also places a word that exposes D directly after each stimulus that could have disturbed D.

// File: rtl/acc16_pkg.sv
package acc16_pkg;
   // field positions in a compute-type word (low 13 bits)
   localparam int YSEL_BIT  = 12;
   localparam int ZX_BIT    = 11;
   localparam int NX_BIT    = 10;
   localparam int ZY_BIT    = 9;
   localparam int NY_BIT    = 8;
   localparam int ADD_BIT   = 7;
   localparam int NO_BIT    = 6;
   localparam int DST_A_BIT = 5;
   localparam int DST_D_BIT = 4;
   localparam int DST_M_BIT = 3;
   localparam int J_LT_BIT  = 2;
   localparam int J_EQ_BIT  = 1;
   localparam int J_GT_BIT  = 0;
   localparam int FIELD_W   = 13;

   typedef struct packed {
      logic is_comp;
      logic y_mem;
      logic zx;
      logic nx;
      logic zy;
      logic ny;
      logic f_add;
      logic neg_out;
      logic ld_a;
      logic ld_d;
      logic st_m;
      logic j_lt;
      logic j_eq;
      logic j_gt;
   } ctrl_t;
endpackage

// File: rtl/acc16_decode.sv
module acc16_decode
   import acc16_pkg::*;
(
   input  logic               type_bit,
   input  logic [FIELD_W-1:0] fields,
   output ctrl_t              ctrl
);
   always_comb begin
      ctrl.is_comp = type_bit;
      // ALU controls are never qualified: out_m follows the ALU always
      ctrl.y_mem   = fields[YSEL_BIT];
      ctrl.zx      = fields[ZX_BIT];
      ctrl.nx      = fields[NX_BIT];
      ctrl.zy      = fields[ZY_BIT];
      ctrl.ny      = fields[NY_BIT];
      ctrl.f_add   = fields[ADD_BIT];
      ctrl.neg_out = fields[NO_BIT];
      // anything that changes state is qualified by the type bit
      ctrl.ld_a    = !type_bit || fields[DST_A_BIT];
      ctrl.ld_d    = type_bit && fields[DST_D_BIT];
      ctrl.st_m    = type_bit && fields[DST_M_BIT];
      ctrl.j_lt    = type_bit && fields[J_LT_BIT];
      ctrl.j_eq    = type_bit && fields[J_EQ_BIT];
      ctrl.j_gt    = type_bit && fields[J_GT_BIT];
   end
endmodule

// File: rtl/acc16_alu.sv
module acc16_alu #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] y_in,
   input  logic              zx,
   input  logic              nx,
   input  logic              zy,
   input  logic              ny,
   input  logic              f_add,
   input  logic              neg_out,
   output logic [DATA_W-1:0] res,
   output logic              zr,
   output logic              ng
);
   logic [DATA_W-1:0] xz, xp, yz, yp, raw;

   always_comb begin
      xz  = zx ? '0 : x_in;
      xp  = nx ? ~xz : xz;
      yz  = zy ? '0 : y_in;
      yp  = ny ? ~yz : yz;
      raw = f_add ? (xp + yp) : (xp & yp);
      res = neg_out ? ~raw : raw;
   end

   assign zr = (res == '0);
   assign ng = res[DATA_W-1];
endmodule

// File: rtl/acc16_pc.sv
module acc16_pc #(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              j_lt,
   input  logic              j_eq,
   input  logic              j_gt,
   input  logic              zr,
   input  logic              ng,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);
   logic              taken;
   logic [ADDR_W-1:0] pc_q;

   assign taken = (j_lt && ng) || (j_eq && zr) || (j_gt && !ng && !zr);

   always_ff @(posedge clk) begin
      if (rst)        pc_q <= '0;
      else if (taken) pc_q <= target;
      else            pc_q <= pc_q + ADDR_W'(1);
   end

   assign pc = pc_q;
endmodule

// File: rtl/acc16_core.sv
module acc16_core
   import acc16_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] instr,
   input  logic [DATA_W-1:0] in_m,
   output logic [DATA_W-1:0] out_m,
   output logic [ADDR_W-1:0] addr_m,
   output logic              wr_m,
   output logic [ADDR_W-1:0] pc
);
   localparam int TYPE_BIT = DATA_W - 1;

   initial begin
      if (DATA_W < FIELD_W + 1)
         $fatal(1, "acc16_core: DATA_W too small for the instruction fields");
      if (ADDR_W > DATA_W - 1)
         $fatal(1, "acc16_core: ADDR_W must leave the type bit out of A");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] a_q, d_q, y_src, alu_res;
   logic              alu_zr, alu_ng;

   acc16_decode u_dec (
      .type_bit (instr[TYPE_BIT]),
      .fields   (instr[FIELD_W-1:0]),
      .ctrl     (ctrl)
   );

   assign y_src = ctrl.y_mem ? in_m : a_q;

   acc16_alu #(.DATA_W(DATA_W)) u_alu (
      .x_in    (d_q),
      .y_in    (y_src),
      .zx      (ctrl.zx),
      .nx      (ctrl.nx),
      .zy      (ctrl.zy),
      .ny      (ctrl.ny),
      .f_add   (ctrl.f_add),
      .neg_out (ctrl.neg_out),
      .res     (alu_res),
      .zr      (alu_zr),
      .ng      (alu_ng)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         d_q <= '0;
      end else begin
         if (ctrl.ld_a) a_q <= ctrl.is_comp ? alu_res : instr;
         if (ctrl.ld_d) d_q <= alu_res;
      end
   end

   acc16_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .j_lt   (ctrl.j_lt),
      .j_eq   (ctrl.j_eq),
      .j_gt   (ctrl.j_gt),
      .zr     (alu_zr),
      .ng     (alu_ng),
      .target (a_q[ADDR_W-1:0]),
      .pc     (pc)
   );

   assign out_m  = alu_res;
   assign addr_m = a_q[ADDR_W-1:0];
   assign wr_m   = ctrl.st_m;
endmodule

// File: rtl/acc16_core_chk.sv
module acc16_core_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] instr,
   input logic [ADDR_W-1:0] out_lo,
   input logic [ADDR_W-1:0] addr_m,
   input logic              wr_m,
   input logic [ADDR_W-1:0] pc
);
   // R5
   store_qual_chk: assert property (@(posedge clk) disable iff (rst)
      wr_m |-> (instr[DATA_W-1] && instr[3]));

   // R1
   const_load_chk: assert property (@(posedge clk) disable iff (rst)
      !instr[DATA_W-1] |=> (addr_m == $past(instr[ADDR_W-1:0])));

   // R9
   const_no_jump_chk: assert property (@(posedge clk) disable iff (rst)
      !instr[DATA_W-1] |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))));

   // R8
   old_a_jump_chk: assert property (@(posedge clk) disable iff (rst)
      (instr[DATA_W-1] && instr[2:0] == 3'b111) |=> (pc == $past(addr_m)));

   // R2
   a_from_alu_chk: assert property (@(posedge clk) disable iff (rst)
      (instr[DATA_W-1] && instr[5]) |=> (addr_m == $past(out_lo)));

   // R7
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (pc == '0 && addr_m == '0));
endmodule

bind acc16_core acc16_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .instr  (instr),
   .out_lo (out_m[ADDR_W-1:0]),
   .addr_m (addr_m),
   .wr_m   (wr_m),
   .pc     (pc)
);

// File: tb/acc16_core_tb.sv
module acc16_core_tb;
   localparam int CLK_PERIOD = 10;

   // op codes, bit order zx nx zy ny add no
   localparam logic [5:0] OP_DPASS = 6'b001010;
   localparam logic [5:0] OP_YPASS = 6'b100010;
   localparam logic [5:0] OP_ADD   = 6'b000010;
   localparam logic [5:0] OP_AND   = 6'b000000;
   localparam logic [5:0] OP_DSUBY = 6'b010011;
   localparam logic [5:0] OP_YSUBD = 6'b000111;
   localparam logic [5:0] OP_NEG1  = 6'b101011;
   localparam logic [5:0] OP_ZERO  = 6'b101010;
   localparam logic [5:0] OP_ONE   = 6'b111111;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr = '0;
   logic [15:0] in_m = '0;
   logic [15:0] out_m;
   logic [14:0] addr_m;
   logic        wr_m;
   logic [14:0] pc;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [15:0] out_m;
      logic        wr_m;
      logic [14:0] addr_m;
      logic [14:0] pc;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   // reference state
   logic [15:0] m_a = '0, m_d = '0;
   logic [14:0] m_pc = '0;

   acc16_core u_dut (
      .clk(clk), .rst(rst), .instr(instr), .in_m(in_m),
      .out_m(out_m), .addr_m(addr_m), .wr_m(wr_m), .pc(pc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] cw(input logic ym, input logic [5:0] op,
                                      input logic [2:0] dst, input logic [2:0] jmp);
      return {3'b111, ym, op, dst, jmp};
   endfunction

   function automatic logic [15:0] ref_alu(input logic [15:0] x, input logic [15:0] y,
                                           input logic [5:0] op);
      logic [15:0] a, b, r;
      a = op[5] ? 16'h0 : x;
      if (op[4]) a = ~a;
      b = op[3] ? 16'h0 : y;
      if (op[2]) b = ~b;
      r = op[1] ? a + b : a & b;
      return op[0] ? ~r : r;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [15:0] got, input logic [15:0] want);
      n_checks++;
      if (got !== want) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, want);
      end
   endtask

   // driver: apply one word, queue the expected outputs, advance the model
   task automatic step(input logic [15:0] w, input logic [15:0] mem,
                       input logic r, input bit chk, input string tag);
      logic [15:0] res;
      logic        taken, comp;
      exp_t        e;
      @(negedge clk);
      rst = r; instr = w; in_m = mem;
      comp = w[15];
      res = ref_alu(m_d, w[12] ? mem : m_a, w[11:6]);
      e.out_m  = res;
      e.wr_m   = comp && w[3];
      e.addr_m = m_a[14:0];
      e.pc     = m_pc;
      if (chk) begin
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
      taken = comp && ((w[2] && res[15]) || (w[1] && res == 0) ||
                       (w[0] && !res[15] && res != 0));
      if (r) begin
         m_a = '0; m_d = '0; m_pc = '0;
      end else begin
         m_pc = taken ? m_a[14:0] : m_pc + 15'd1;
         if (!comp) m_a = w;
         else begin
            if (w[5]) m_a = res;
            if (w[4]) m_d = res;
         end
      end
   endtask

   // monitor
   initial begin
      exp_t  e;
      string t;
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "out_m",  out_m, e.out_m);
            check(t, "wr_m",   {15'd0, wr_m}, {15'd0, e.wr_m});
            check(t, "addr_m", {1'b0, addr_m}, {1'b0, e.addr_m});
            check(t, "pc",     {1'b0, pc}, {1'b0, e.pc});
         end
      end
   end

   initial begin
      #(CLK_PERIOD*5000);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      step(16'h0000, 16'h0, 1'b1, 0, "");
      step(16'h0000, 16'h0, 1'b1, 0, "");
      step(16'h0005, 16'h0, 1'b0, 1, "R7 reset state");
      step(cw(0, OP_YPASS, 3'b010, 3'b000), 16'h0, 1'b0, 1, "R4 ypass");
      step(16'h0123, 16'h0, 1'b0, 1, "R1 const");
      step(cw(0, OP_ADD,   3'b010, 3'b000), 16'h0, 1'b0, 1, "R4 add");
      step(cw(1, OP_AND,   3'b010, 3'b000), 16'h00F0, 1'b0, 1, "R4 and mem");
      step(cw(1, OP_DSUBY, 3'b001, 3'b000), 16'h0010, 1'b0, 1, "R5 store");
      step(cw(1, OP_YSUBD, 3'b111, 3'b000), 16'h1234, 1'b0, 1, "R5 all dests");
      step(16'h7FFF, 16'h0, 1'b0, 1, "R9 const fields");
      step(cw(0, OP_DPASS, 3'b000, 3'b000), 16'h0, 1'b0, 1, "R9 D kept R3");
      step(cw(0, OP_NEG1,  3'b100, 3'b000), 16'h0, 1'b0, 1, "R2 load ffff");
      step(16'h0040, 16'h0, 1'b0, 1, "R2 addr low bits");
      step(cw(0, OP_ZERO,  3'b000, 3'b010), 16'h0, 1'b0, 1, "R6 eq");
      step(16'h0100, 16'h0, 1'b0, 1, "R6 after eq");
      step(cw(0, OP_ONE,   3'b000, 3'b100), 16'h0, 1'b0, 1, "R6 lt not");
      step(cw(0, OP_NEG1,  3'b000, 3'b100), 16'h0, 1'b0, 1, "R6 lt");
      step(16'h0200, 16'h0, 1'b0, 1, "R6 after lt");
      step(cw(0, OP_ONE,   3'b000, 3'b001), 16'h0, 1'b0, 1, "R6 gt");
      step(cw(0, OP_ZERO,  3'b000, 3'b101), 16'h0, 1'b0, 1, "R6 lt|gt zero");
      step(16'h0300, 16'h0, 1'b0, 1, "R6 after no jump");
      step(cw(0, OP_NEG1,  3'b100, 3'b111), 16'h0, 1'b0, 1, "R8 jump old A");
      step(16'h7FFF, 16'h0, 1'b0, 1, "R8 new A visible");
      step(cw(0, OP_ZERO,  3'b000, 3'b111), 16'h0, 1'b0, 1, "R6 jump top");
      step(16'h0001, 16'h0, 1'b0, 1, "R6 at top");
      step(16'h0002, 16'h0, 1'b0, 1, "R6 wrap");
      step(cw(0, OP_NEG1,  3'b110, 3'b111), 16'h0, 1'b1, 1, "R7 mid reset");
      step(16'h0002, 16'h0, 1'b0, 1, "R7 after reset");
      step(cw(0, OP_DPASS, 3'b000, 3'b000), 16'h0, 1'b0, 1, "R7 D cleared R3");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule